// File: doc/BRIEF.md
# Vector Element Multi-Issue Dispatcher

This block sits between instruction decode and a set of pipelined execution units. It takes decoded vector instructions from a small internal queue and splits each into scalar element micro-ops. Each instruction carries an opcode, a vector length and a base register for the destination and each of its two sources. Every cycle the block fills a fixed number of issue slots with these element micro-ops, in order. Element k of an instruction reads and writes the base registers plus k.

Issue does not pause at a vector instruction. When the current instruction leaves slots unused, elements from the following instructions fill them in the same cycle. When an instruction has more elements than there are free slots, it issues what fits and resumes from the next element on the following cycle. All execution units except divide accept new work every cycle, so the full slot count is available again each cycle. The divide unit is not pipelined. It gets at most one element at a time and reports busy while it works. Elements waiting on it hold back everything behind them, so program order is kept.

Top module: `vec_elem_dispatch`

## Requirements
- R1: Each accepted instruction with vector length n produces exactly n element micro-ops. They issue in program order and, within an instruction, in ascending element order. Valid slots in a cycle always run contiguously from slot 0.
- R2: Element k carries the instruction's opcode, destination base+k, source A base+k and source B base+k, each taken modulo 64 (6-bit register index).
- R3: When an instruction's remaining elements leave slots free, elements of the following queued instructions take those slots in the same cycle. With 8 slots, an instruction of 3 elements and one of 4 issue together in a single cycle.
- R4: An instruction with more remaining elements than free slots issues as many as fit, filling every slot. It continues from the next element index in the following cycle.
- R5: An instruction with vector length 0 retires without using a slot and does not stop later instructions from issuing in the same cycle.
- R6: Opcode 4'hD is divide. At most one divide element issues per cycle, and none issues while div_busy is high. A blocked divide element holds back all later elements.
- R7: For non-divide work, all slots are available again every cycle, with no gap between cycles.
- R8: The queue holds 8 instructions. in_ready is high while it has room, an instruction is accepted on a clock edge where in_valid and in_ready are both high, and in_ready is low while 8 instructions are waiting.
- R9: In reset, the queue is empty, no slot is valid and in_ready is high. An accepted instruction can issue in the cycle after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_ready | output | 1 | Queue has room for an instruction |
| in_op | input | 4 | Opcode of the offered instruction |
| in_vl | input | 5 | Vector length (0 to 31) |
| in_dst | input | 6 | Destination base register |
| in_srca | input | 6 | Source A base register |
| in_srcb | input | 6 | Source B base register |
| div_busy | input | 1 | Divide unit cannot accept an element |
| iss_valid | output | 8 | Per-slot valid, slot 0 oldest |
| iss_op | output | 32 | Per-slot opcode, 4 bits per slot |
| iss_dst | output | 48 | Per-slot destination register, 6 bits per slot |
| iss_srca | output | 48 | Per-slot source A register, 6 bits per slot |
| iss_srcb | output | 48 | Per-slot source B register, 6 bits per slot |

## Verification
The bench builds the block with its defaults: 8 slots, an 8-entry queue and divide on opcode 4'hD. Vector lengths up to 31 are therefore several times the slot count, so one instruction can span up to four issue cycles. Eight queue entries are enough to pile up a backlog behind a blocked divide and then see several instructions packed into one cycle. A 6-bit register space lets random base registers near 63 exercise index wraparound. A bench-side divide unit with a three-cycle busy time, plus forced busy windows, drives the ordering and stall cases.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;

    // Field widths shared by every unit of the dispatcher.
    localparam int VL_W  = 5;   // vector length field, 0..31
    localparam int REG_W = 6;   // register index, 64 registers
    localparam int OP_W  = 4;   // opcode field

    // Decoded vector instruction held in the queue.
    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [VL_W-1:0]  vl;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] srca;
        logic [REG_W-1:0] srcb;
    } instr_t;

    // Scalar element micro-op placed in one issue slot.
    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] srca;
        logic [REG_W-1:0] srcb;
    } uop_t;

endpackage

// File: rtl/vdisp_queue.sv
module vdisp_queue
    import vdisp_pkg::*;
#(
    parameter  int QDEPTH = 8,
    localparam int IDX_W  = $clog2(QDEPTH),
    localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  instr_t                  push_data,
    input  logic [CNT_W-1:0]        pops,
    output instr_t [QDEPTH-1:0]     win,
    output logic [CNT_W-1:0]        count,
    output logic                    not_full
);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t s_d, s_q;
    instr_t  mem_q [QDEPTH];

    // Next pointer and occupancy values.
    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.tail = s_q.tail + IDX_W'(1);
        end
        s_d.head = s_q.head + IDX_W'(pops);
        s_d.cnt  = s_q.cnt - pops + CNT_W'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Entry storage needs no reset: only entries below count are read.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[s_q.tail] <= push_data;
        end
    end

    // Window of entries in program order, oldest first.
    for (genvar j = 0; j < QDEPTH; j++) begin : g_win
        assign win[j] = mem_q[s_q.head + IDX_W'(j)];
    end

    assign count    = s_q.cnt;
    assign not_full = (s_q.cnt < CNT_W'(QDEPTH));

endmodule

// File: rtl/vdisp_packer.sv
module vdisp_packer
    import vdisp_pkg::*;
#(
    parameter  int              SLOTS  = 8,
    parameter  int              QDEPTH = 8,
    parameter  logic [OP_W-1:0] DIV_OP = 4'hD,
    localparam int              CNT_W  = $clog2(QDEPTH + 1)
) (
    input  instr_t [QDEPTH-1:0] win,
    input  logic [CNT_W-1:0]    count,
    input  logic [VL_W-1:0]     elem_q,
    input  logic                div_busy,
    output uop_t [SLOTS-1:0]    uops,
    output logic [SLOTS-1:0]    valid,
    output logic [CNT_W-1:0]    pops,
    output logic [VL_W-1:0]     elem_d
);

    function automatic uop_t make_uop(instr_t ins, int k);
        uop_t u;
        u.op   = ins.op;
        u.dst  = ins.dst  + REG_W'(k);
        u.srca = ins.srca + REG_W'(k);
        u.srcb = ins.srcb + REG_W'(k);
        return u;
    endfunction

    int   used;
    int   start;
    int   rem;
    int   take;
    logic halt;
    logic div_used;

    // Greedy fill: walk the queue window oldest first, placing elements
    // into the lowest free slots until slots run out or an entry blocks.
    always_comb begin
        uops     = '0;
        valid    = '0;
        pops     = '0;
        elem_d   = elem_q;
        used     = 0;
        start    = 0;
        rem      = 0;
        take     = 0;
        halt     = 1'b0;
        div_used = 1'b0;
        for (int j = 0; j < QDEPTH; j++) begin
            if (!halt && (j < int'(count))) begin
                start = (j == 0) ? int'(elem_q) : 0;
                rem   = int'(win[j].vl) - start;
                if (rem <= 0) begin
                    // Empty instruction: retire, no slot.
                    pops   = pops + CNT_W'(1);
                    elem_d = '0;
                end else if (win[j].op == DIV_OP) begin
                    if (div_busy || div_used || (used >= SLOTS)) begin
                        halt = 1'b1;
                    end else begin
                        for (int s = 0; s < SLOTS; s++) begin
                            if (s == used) begin
                                uops[s]  = make_uop(win[j], start);
                                valid[s] = 1'b1;
                            end
                        end
                        used     = used + 1;
                        div_used = 1'b1;
                        if (rem == 1) begin
                            pops   = pops + CNT_W'(1);
                            elem_d = '0;
                        end else begin
                            elem_d = VL_W'(start + 1);
                            halt   = 1'b1;
                        end
                    end
                end else begin
                    take = (rem < (SLOTS - used)) ? rem : (SLOTS - used);
                    if (take == 0) begin
                        halt = 1'b1;
                    end else begin
                        for (int s = 0; s < SLOTS; s++) begin
                            if ((s >= used) && (s < used + take)) begin
                                uops[s]  = make_uop(win[j], start + s - used);
                                valid[s] = 1'b1;
                            end
                        end
                        used = used + take;
                        if (take == rem) begin
                            pops   = pops + CNT_W'(1);
                            elem_d = '0;
                        end else begin
                            elem_d = VL_W'(start + take);
                            halt   = 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/vec_elem_dispatch.sv
module vec_elem_dispatch
    import vdisp_pkg::*;
#(
    parameter  int              SLOTS  = 8,
    parameter  int              QDEPTH = 8,
    parameter  logic [OP_W-1:0] DIV_OP = 4'hD,
    localparam int              CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [OP_W-1:0]         in_op,
    input  logic [VL_W-1:0]         in_vl,
    input  logic [REG_W-1:0]        in_dst,
    input  logic [REG_W-1:0]        in_srca,
    input  logic [REG_W-1:0]        in_srcb,
    input  logic                    div_busy,
    output logic [SLOTS-1:0]        iss_valid,
    output logic [SLOTS*OP_W-1:0]   iss_op,
    output logic [SLOTS*REG_W-1:0]  iss_dst,
    output logic [SLOTS*REG_W-1:0]  iss_srca,
    output logic [SLOTS*REG_W-1:0]  iss_srcb
);

    typedef struct packed {
        logic [VL_W-1:0] elem;   // next element index of the head entry
    } dstate_t;

    dstate_t             st_d, st_q;
    instr_t              push_data;
    instr_t [QDEPTH-1:0] win;
    logic [CNT_W-1:0]    q_count;
    logic [CNT_W-1:0]    pops;
    logic [VL_W-1:0]     elem_nx;
    logic                not_full;
    logic                push;
    uop_t [SLOTS-1:0]    uops;

    assign push_data = '{op: in_op, vl: in_vl, dst: in_dst, srca: in_srca, srcb: in_srcb};
    assign push      = in_valid && not_full;
    assign in_ready  = not_full;

    vdisp_queue #(
        .QDEPTH (QDEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pops      (pops),
        .win       (win),
        .count     (q_count),
        .not_full  (not_full)
    );

    vdisp_packer #(
        .SLOTS  (SLOTS),
        .QDEPTH (QDEPTH),
        .DIV_OP (DIV_OP)
    ) u_packer (
        .win      (win),
        .count    (q_count),
        .elem_q   (st_q.elem),
        .div_busy (div_busy),
        .uops     (uops),
        .valid    (iss_valid),
        .pops     (pops),
        .elem_d   (elem_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.elem = elem_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_flat
        assign iss_op  [s*OP_W  +: OP_W ] = uops[s].op;
        assign iss_dst [s*REG_W +: REG_W] = uops[s].dst;
        assign iss_srca[s*REG_W +: REG_W] = uops[s].srca;
        assign iss_srcb[s*REG_W +: REG_W] = uops[s].srcb;
    end

endmodule

// File: rtl/vdisp_chk.sv
module vdisp_chk
    import vdisp_pkg::*;
#(
    parameter  int              SLOTS  = 8,
    parameter  int              QDEPTH = 8,
    parameter  logic [OP_W-1:0] DIV_OP = 4'hD,
    localparam int              CNT_W  = $clog2(QDEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  div_busy,
    input logic [SLOTS-1:0]      iss_valid,
    input logic [SLOTS*OP_W-1:0] iss_op,
    input logic [CNT_W-1:0]      q_count
);

    logic [SLOTS-1:0] div_mask;

    for (genvar g = 0; g < SLOTS; g++) begin : g_div
        assign div_mask[g] = iss_valid[g] && (iss_op[g*OP_W +: OP_W] == DIV_OP);
    end

    // R1
    slots_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid & (iss_valid + SLOTS'(1))) == '0);

    // R6
    one_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(div_mask) <= 1);

    // R6
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (div_mask == '0));

    // R8
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH));

    // R9
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0) |-> (iss_valid == '0));

endmodule

bind vec_elem_dispatch vdisp_chk #(
    .SLOTS  (SLOTS),
    .QDEPTH (QDEPTH),
    .DIV_OP (DIV_OP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_busy  (div_busy),
    .iss_valid (iss_valid),
    .iss_op    (iss_op),
    .q_count   (q_count)
);

// File: tb/vec_elem_dispatch_tb.sv
`timescale 1ns/100ps
module vec_elem_dispatch_tb;
    import vdisp_pkg::*;

    localparam int              SLOTS   = 8;
    localparam int              QDEPTH  = 8;
    localparam logic [OP_W-1:0] DIV_OP  = 4'hD;
    localparam int              DIV_LAT = 3;
    localparam int              SMAX    = 8192;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [OP_W-1:0]        in_op = '0;
    logic [VL_W-1:0]        in_vl = '0;
    logic [REG_W-1:0]       in_dst = '0;
    logic [REG_W-1:0]       in_srca = '0;
    logic [REG_W-1:0]       in_srcb = '0;
    logic                   div_busy = 1'b0;
    logic [SLOTS-1:0]       iss_valid;
    logic [SLOTS*OP_W-1:0]  iss_op;
    logic [SLOTS*REG_W-1:0] iss_dst;
    logic [SLOTS*REG_W-1:0] iss_srca;
    logic [SLOTS*REG_W-1:0] iss_srcb;

    always #2.5 clk = ~clk;

    vec_elem_dispatch #(.SLOTS(SLOTS), .QDEPTH(QDEPTH), .DIV_OP(DIV_OP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_vl(in_vl), .in_dst(in_dst), .in_srca(in_srca),
        .in_srcb(in_srcb), .div_busy(div_busy), .iss_valid(iss_valid),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_srca(iss_srca), .iss_srcb(iss_srcb)
    );

    // Expected element stream in issue order.
    logic [OP_W-1:0]  e_op   [SMAX];
    logic [REG_W-1:0] e_dst  [SMAX];
    logic [REG_W-1:0] e_sa   [SMAX];
    logic [REG_W-1:0] e_sb   [SMAX];
    int sh = 0;
    int st = 0;

    int   checks = 0;
    int   fails = 0;
    int   div_cnt = 0;
    logic force_busy = 1'b0;
    logic accepted = 1'b0;

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Elements the requirements allow this cycle (R3 R4 R5 R6 R7).
    function automatic int expected_take(input logic busy);
        int n = 0;
        logic divt = 1'b0;
        int idx = sh;
        while (n < SLOTS && idx < st) begin
            if (e_op[idx] == DIV_OP) begin
                if (busy || divt) break;
                divt = 1'b1;
            end
            n++;
            idx++;
        end
        return n;
    endfunction

    function automatic logic takes_div(input int n);
        logic d = 1'b0;
        for (int i = 0; i < n; i++) if (e_op[sh+i] == DIV_OP) d = 1'b1;
        return d;
    endfunction

    // Append an accepted instruction to the expected stream (R1 R2).
    task automatic append(input logic [OP_W-1:0] op, input logic [VL_W-1:0] vl,
                          input logic [REG_W-1:0] d, input logic [REG_W-1:0] a,
                          input logic [REG_W-1:0] b);
        for (int k = 0; k < int'(vl); k++) begin
            e_op[st]  = op;
            e_dst[st] = d + REG_W'(k);
            e_sa[st]  = a + REG_W'(k);
            e_sb[st]  = b + REG_W'(k);
            st++;
        end
    endtask

    task automatic sample();
        int n;
        int bad;
        n = expected_take(div_busy);
        check(iss_valid == SLOTS'((1 << n) - 1), "R3 R4 R6 R7 slot fill",
              int'(iss_valid), (1 << n) - 1);
        if (n > 0) begin
            bad = -1;
            for (int s = 0; s < n; s++) begin
                if (bad < 0 &&
                    (iss_op[s*OP_W +: OP_W] != e_op[sh+s] ||
                     iss_dst[s*REG_W +: REG_W] != e_dst[sh+s] ||
                     iss_srca[s*REG_W +: REG_W] != e_sa[sh+s] ||
                     iss_srcb[s*REG_W +: REG_W] != e_sb[sh+s])) bad = s;
            end
            if (bad < 0) check(1'b1, "R1 R2 element content", 0, 0);
            else check(1'b0, "R1 R2 element dst in slot", int'(iss_dst[bad*REG_W +: REG_W]),
                       int'(e_dst[sh+bad]));
        end
        if (takes_div(n)) div_cnt = DIV_LAT;
        else if (div_cnt > 0) div_cnt--;
        sh += n;
        if (in_valid && in_ready) begin
            append(in_op, in_vl, in_dst, in_srca, in_srcb);
            accepted = 1'b1;
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        sample();
        @(posedge clk);
        #1;
        div_busy = force_busy || (div_cnt > 0);
    endtask

    task automatic set_force(input logic v);
        force_busy = v;
        div_busy = force_busy || (div_cnt > 0);
    endtask

    task automatic push(input logic [OP_W-1:0] op, input logic [VL_W-1:0] vl,
                        input logic [REG_W-1:0] d, input logic [REG_W-1:0] a,
                        input logic [REG_W-1:0] b, input logic relax);
        int waited = 0;
        in_valid = 1'b1; in_op = op; in_vl = vl; in_dst = d; in_srca = a; in_srcb = b;
        accepted = 1'b0;
        while (!accepted) begin
            cyc();
            waited++;
            if (relax && waited > 4 && force_busy) set_force(1'b0);
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (sh < st) cyc();
        repeat (3) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        // R9 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(iss_valid == '0, "R9 reset no slot valid", int'(iss_valid), 0);
        check(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R4: long instruction spans cycles 8, 8, 4; R2 wraparound at 63.
        push(4'h1, 5'd20, 6'd10, 6'd20, 6'd30, 1'b0);
        push(4'h2, 5'd5, 6'd62, 6'd60, 6'd63, 1'b0);
        drain();

        // R8: blocked divide at head fills the queue.
        set_force(1'b1);
        push(DIV_OP, 5'd2, 6'd1, 6'd2, 6'd3, 1'b0);
        push(4'h3, 5'd4, 6'd8, 6'd16, 6'd24, 1'b0);
        push(4'h4, 5'd4, 6'd40, 6'd41, 6'd42, 1'b0);
        push(4'h5, 5'd0, 6'd0, 6'd0, 6'd0, 1'b0);
        push(4'h6, 5'd3, 6'd5, 6'd6, 6'd7, 1'b0);
        push(4'h7, 5'd1, 6'd50, 6'd51, 6'd52, 1'b0);
        push(4'h8, 5'd8, 6'd60, 6'd61, 6'd62, 1'b0);
        push(4'h9, 5'd0, 6'd9, 6'd9, 6'd9, 1'b0);
        cyc();
        check(in_ready == 1'b0, "R8 full queue in_ready", int'(in_ready), 0);
        check(iss_valid == '0, "R6 blocked divide holds later work", int'(iss_valid), 0);
        set_force(1'b0);
        drain();

        // R5 and R3: divide, two empty instructions, then 3 + 4 elements.
        set_force(1'b1);
        push(DIV_OP, 5'd1, 6'd11, 6'd12, 6'd13, 1'b0);
        push(4'h1, 5'd0, 6'd0, 6'd0, 6'd0, 1'b0);
        push(4'h2, 5'd0, 6'd0, 6'd0, 6'd0, 1'b0);
        push(4'h3, 5'd3, 6'd20, 6'd21, 6'd22, 1'b0);
        push(4'h4, 5'd4, 6'd30, 6'd31, 6'd32, 1'b0);
        cyc();
        set_force(1'b0);
        #1;
        check($countones(iss_valid) == SLOTS, "R5 R3 empty entries leave slots to later ones",
              $countones(iss_valid), SLOTS);
        drain();

        // Random mix.
        for (int i = 0; i < 300; i++) begin
            logic [OP_W-1:0] op;
            logic [VL_W-1:0] vl;
            if ($urandom % 10 == 0) set_force(~force_busy);
            if ($urandom % 4 == 0) begin
                op = DIV_OP;
                vl = VL_W'($urandom % 5);
            end else begin
                op = OP_W'($urandom % 13);
                vl = VL_W'($urandom % 32);
            end
            push(op, vl, REG_W'($urandom), REG_W'($urandom), REG_W'($urandom), 1'b1);
            repeat ($urandom % 3) cyc();
        end
        set_force(1'b0);
        drain();
        check(sh == st, "R1 all elements issued", sh, st);
        finish_up();
    end

endmodule